// File: doc/BRIEF.md
# Interpolating Sample Playback Buffer

This block holds a queue of signed output samples that a host pushes in, and plays them back one step per PWM-cycle tick. It does not hand the stored samples through unchanged. It spreads each step between two consecutive entries over a programmable number of ticks and fills the gaps by linear interpolation. The result is a smooth setpoint for a downstream controller, plus a flag that says whether playback is active.

The host writes either raw samples or integer samples. An integer sample is multiplied by a fixed-point scale factor that the host can program. The block reports how full the queue is. It emits a single-cycle notice when the fill level drops into a low band, so the host knows to send more data. A write into a full queue is refused and flagged. When the queue runs dry after playback has started, the block stops the output, clears its state and rewinds both pointers.

Top module: `interp_playback`

## Requirements
- R1: After reset the output value is 0, the running flag is 0, the notice and overflow outputs are 0, and the fill level reads DEPTH (an empty queue reads as DEPTH).
- R2: The tick counter starts at 0 after reset or after a stop. A tick with the counter at or above the interval N resets the counter and, if the queue holds data, fetches one entry. Any other tick increments the counter. So a fetch happens on every (N+1)-th tick. On a fetch, the held "next" value moves to "last", the popped entry becomes "next", the output takes the old "next", and the running flag is set.
- R3: On a tick that does not fetch, while playback is active, with k the incremented counter value (1..N), the output becomes last + (next − last)·k/(N+1). The quotient is truncated toward zero.
- R4: In cycles without a tick, the output and the running flag hold their values.
- R5: A fetching tick that finds the queue empty after playback had data clears the running flag. It sets the output, "last" and "next" to 0, and resets both pointers to 0. The first fetch of the next run therefore outputs 0.
- R6: A fetching tick that finds the queue empty while playback has not started changes neither the output nor the running flag.
- R7: An integer write stores floor(value·scale / 256), saturated to the sample range. The scale is an unsigned 16-bit value with 8 fraction bits. It resets to 2 (one 128th), and asserting scale_load for one cycle replaces it. A raw write stores the value unchanged.
- R8: The fill level is write − read when the write pointer is ahead of the read pointer. Otherwise it is DEPTH − read + write.
- R9: low_notify pulses for exactly one cycle, in the cycle after the fill level enters the band 0 < level < notify_level from outside it. It does not pulse again while the level stays in the band.
- R10: A write that would make the write pointer equal the read pointer is dropped. overflow pulses in the following cycle, so at most DEPTH−1 entries are held.
- R11: A write in the same cycle as a stop (R5) is stored at entry 0, so the fill level afterwards is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Push one sample this cycle |
| wr_int | input | 1 | Sample is an integer to be scaled |
| wr_data | input | SAMPLE_W | Signed sample or integer |
| scale_load | input | 1 | Load a new integer scale |
| scale_value | input | SCALE_W | Unsigned scale, SCALE_FRAC fraction bits |
| interp_len | input | CNT_W | Interval N; N+1 ticks per stored step |
| tick | input | 1 | PWM-cycle strobe, one cycle wide |
| notify_level | input | PTR_W+1 | Low-band threshold |
| out_value | output | SAMPLE_W | Current setpoint |
| running | output | 1 | Playback active |
| fill_level | output | PTR_W+1 | Queue fill level |
| low_notify | output | 1 | Entry into low band, one-cycle pulse |
| overflow | output | 1 | Write refused, one-cycle pulse |

## Verification
The hardest case to reach is a full queue. To get there, the stimulus pushes DEPTH−1 entries from rewound pointers, then makes one more write, and checks that the fill level stays put and the overflow pulse appears. It then pops two entries and writes two more so that the write pointer wraps behind the read pointer, which exercises the second branch of the level formula. A second awkward case is a write that coincides with the stopping tick. The bench drives the write and the tick in the same cycle, then proves that the sample landed at entry 0 by playing it back.

// File: rtl/playback_pkg.sv
// Shared types for the interpolating playback buffer.
package playback_pkg;

    // What a tick does to the playback state.
    typedef enum logic [2:0] {
        TK_NONE  = 3'd0,   // no tick this cycle
        TK_STEP  = 3'd1,   // counter advances, output interpolates
        TK_FETCH = 3'd2,   // counter wraps and one entry is popped
        TK_HALT  = 3'd3,   // counter wraps on a dry queue after data
        TK_WRAP  = 3'd4    // counter wraps on a dry queue while idle
    } tick_kind_e;

endpackage

// File: rtl/playback_store.sv
// Circular sample store with separate read and write pointers.
// Assumes DEPTH is a power of two so pointers wrap naturally.
// A stop rewinds both pointers; a write in that cycle lands at entry 0.
module playback_store #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 2048,
    parameter int PTR_W    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic signed [SAMPLE_W-1:0] wr_sample,
    input  logic                       pop,
    input  logic                       stop,
    output logic signed [SAMPLE_W-1:0] rd_sample,
    output logic                       empty,
    output logic [PTR_W:0]             level,
    output logic                       overflow
);
    localparam logic [PTR_W:0] DEPTH_V = (PTR_W+1)'(DEPTH);

    logic signed [SAMPLE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q, waddr;
    logic             full, accept;
    logic             overflow_q;

    // Decode full state and where an accepted write goes.
    always_comb begin
        full   = ((wr_q + PTR_W'(1)) == rd_q);
        accept = wr_en && (stop || !full);
        waddr  = stop ? '0 : wr_q;
        empty  = (wr_q == rd_q);
    end

    // Fill level as write-ahead distance, empty reading as DEPTH.
    always_comb begin
        if (wr_q > rd_q) level = {1'b0, wr_q} - {1'b0, rd_q};
        else             level = DEPTH_V - {1'b0, rd_q} + {1'b0, wr_q};
    end

    assign rd_sample = mem[rd_q];
    assign overflow  = overflow_q;

    // Sample storage write port.
    always_ff @(posedge clk) begin
        if (accept) mem[waddr] <= wr_sample;
    end

    // Pointer movement, rewind on stop, overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= '0;
            rd_q       <= '0;
            overflow_q <= 1'b0;
        end else begin
            overflow_q <= wr_en && !stop && full;
            if (stop) begin
                rd_q <= '0;
                wr_q <= accept ? PTR_W'(1) : '0;
            end else begin
                if (accept) wr_q <= wr_q + PTR_W'(1);
                if (pop)    rd_q <= rd_q + PTR_W'(1);
            end
        end
    end

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R2
    AST_STOP_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en) |=> (wr_q == '0) && (rd_q == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !stop) |=> (wr_q == $past(wr_q))); // R10

endmodule

// File: rtl/playback_scaler.sv
// Integer sample scaling with a programmable fixed-point factor.
// Assumes the scale is unsigned with SCALE_FRAC fraction bits; result is
// floored by an arithmetic shift and saturated to the sample range.
module playback_scaler #(
    parameter int                SAMPLE_W   = 16,
    parameter int                SCALE_W    = 16,
    parameter int                SCALE_FRAC = 8,
    parameter logic [SCALE_W-1:0] SCALE_RST = SCALE_W'(2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scale_load,
    input  logic [SCALE_W-1:0]         scale_in,
    input  logic                       is_int,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic signed [SAMPLE_W-1:0] sample_out
);
    localparam int PRW = SAMPLE_W + SCALE_W + 1;
    localparam logic signed [PRW-1:0] MAX_V = {{(PRW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PRW-1:0] MIN_V = {{(PRW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic [SCALE_W-1:0]    scale_q;
    logic signed [PRW-1:0] prod, shifted;
    logic signed [SAMPLE_W-1:0] sat_v;

    // Hold the current scale factor.
    always_ff @(posedge clk) begin
        if (!rst_n)          scale_q <= SCALE_RST;
        else if (scale_load) scale_q <= scale_in;
    end

    // Multiply, floor-shift and saturate an integer sample.
    always_comb begin
        prod    = PRW'(sample_in) * $signed(PRW'(scale_q));
        shifted = prod >>> SCALE_FRAC;
        if (shifted > MAX_V)      sat_v = MAX_V[SAMPLE_W-1:0];
        else if (shifted < MIN_V) sat_v = MIN_V[SAMPLE_W-1:0];
        else                      sat_v = shifted[SAMPLE_W-1:0];
        sample_out = is_int ? sat_v : sample_in;
    end

endmodule

// File: rtl/playback_lerp.sv
// Linear interpolation between two samples at position k of N+1.
// Assumes 1 <= k <= N; the quotient truncates toward zero.
module playback_lerp #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic signed [SAMPLE_W-1:0] last_v,
    input  logic signed [SAMPLE_W-1:0] next_v,
    input  logic [CNT_W:0]             k,
    input  logic [CNT_W-1:0]           n,
    output logic signed [SAMPLE_W-1:0] result
);
    localparam int DW = SAMPLE_W + CNT_W + 2;

    logic signed [DW-1:0] diff_w, prod_w, den_w, quot_w, sum_w;

    // Scale the step by k and divide by the interval length.
    always_comb begin
        diff_w = DW'(next_v) - DW'(last_v);
        prod_w = diff_w * $signed(DW'(k));
        den_w  = $signed(DW'(n) + DW'(1'b1));
        quot_w = prod_w / den_w;
        sum_w  = DW'(last_v) + quot_w;
        result = sum_w[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/playback_interp.sv
// Tick-driven playback engine: counts ticks, pops on counter wrap,
// interpolates between pops, and stops when the queue runs dry.
// Assumes tick is a one-cycle strobe.
module playback_interp
    import playback_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           n,
    input  logic                       empty,
    input  logic signed [SAMPLE_W-1:0] rd_sample,
    output logic                       pop,
    output logic                       stop,
    output logic signed [SAMPLE_W-1:0] out_value,
    output logic                       running
);
    logic [CNT_W-1:0]           cnt_q;
    logic signed [SAMPLE_W-1:0] last_q, next_q, out_q, lerp_v;
    logic                       had_q, run_q;
    logic [CNT_W:0]             k;
    tick_kind_e                 kind;

    assign k = {1'b0, cnt_q} + (CNT_W+1)'(1);

    playback_lerp #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lerp (
        .last_v (last_q),
        .next_v (next_q),
        .k      (k),
        .n      (n),
        .result (lerp_v)
    );

    // Classify this cycle's tick.
    always_comb begin
        kind = TK_NONE;
        if (tick) begin
            if (cnt_q >= n) begin
                if (!empty)     kind = TK_FETCH;
                else if (had_q) kind = TK_HALT;
                else            kind = TK_WRAP;
            end else begin
                kind = TK_STEP;
            end
        end
        pop  = (kind == TK_FETCH);
        stop = (kind == TK_HALT);
    end

    // Advance playback state according to the tick kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            next_q <= '0;
            out_q  <= '0;
            had_q  <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            case (kind)
                TK_FETCH: begin
                    cnt_q  <= '0;
                    last_q <= next_q;
                    next_q <= rd_sample;
                    out_q  <= next_q;
                    had_q  <= 1'b1;
                    run_q  <= 1'b1;
                end
                TK_HALT: begin
                    cnt_q  <= '0;
                    last_q <= '0;
                    next_q <= '0;
                    out_q  <= '0;
                    had_q  <= 1'b0;
                    run_q  <= 1'b0;
                end
                TK_WRAP: cnt_q <= '0;
                TK_STEP: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (had_q) begin
                        out_q <= lerp_v;
                        run_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_value = out_q;
    assign running   = run_q;

    AST_HALT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> (out_q == '0)); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_q) && $stable(run_q)); // R4

endmodule

// File: rtl/playback_watermark.sv
// Low-level notice: one pulse when the fill level enters the low band.
// Assumes the band is 0 < level < threshold; the remembered state starts
// as "in band" so no pulse follows reset by itself.
module playback_watermark #(
    parameter int PTR_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PTR_W:0] level,
    input  logic [PTR_W:0] threshold,
    output logic           notify
);
    logic in_band, in_band_q, notify_q;

    assign in_band = (level != '0) && (level < threshold);

    // Remember band membership and pulse on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_band_q <= 1'b1;
            notify_q  <= 1'b0;
        end else begin
            in_band_q <= in_band;
            notify_q  <= in_band && !in_band_q;
        end
    end

    assign notify = notify_q;

    AST_NOTIFY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        notify_q |=> !notify_q); // R9

endmodule

// File: rtl/interp_playback.sv
// Interpolating sample playback buffer top level.
// Host pushes raw or scaled samples; each tick advances playback and the
// output ramps linearly between stored entries over interp_len+1 ticks.
module interp_playback #(
    parameter int SAMPLE_W   = 16,
    parameter int DEPTH      = 2048,
    parameter int CNT_W      = 8,
    parameter int SCALE_W    = 16,
    parameter int SCALE_FRAC = 8,
    parameter int PTR_W      = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       wr_int,
    input  logic signed [SAMPLE_W-1:0] wr_data,
    input  logic                       scale_load,
    input  logic [SCALE_W-1:0]         scale_value,
    input  logic [CNT_W-1:0]           interp_len,
    input  logic                       tick,
    input  logic [PTR_W:0]             notify_level,
    output logic signed [SAMPLE_W-1:0] out_value,
    output logic                       running,
    output logic [PTR_W:0]             fill_level,
    output logic                       low_notify,
    output logic                       overflow
);
    localparam logic [SCALE_W-1:0] SCALE_ONE_128 = SCALE_W'((1 << SCALE_FRAC) / 128);

    logic signed [SAMPLE_W-1:0] wr_sample, rd_sample;
    logic                       pop, stop, empty;

    playback_scaler #(
        .SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W),
        .SCALE_FRAC(SCALE_FRAC), .SCALE_RST(SCALE_ONE_128)
    ) u_scaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scale_load (scale_load),
        .scale_in   (scale_value),
        .is_int     (wr_int),
        .sample_in  (wr_data),
        .sample_out (wr_sample)
    );

    playback_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_valid),
        .wr_sample (wr_sample),
        .pop       (pop),
        .stop      (stop),
        .rd_sample (rd_sample),
        .empty     (empty),
        .level     (fill_level),
        .overflow  (overflow)
    );

    playback_interp #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_interp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .n         (interp_len),
        .empty     (empty),
        .rd_sample (rd_sample),
        .pop       (pop),
        .stop      (stop),
        .out_value (out_value),
        .running   (running)
    );

    playback_watermark #(.PTR_W(PTR_W)) u_mark (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fill_level),
        .threshold (notify_level),
        .notify    (low_notify)
    );

endmodule

// File: tb/tb_interp_playback.sv
// Directed bench for the interpolating playback buffer.
module tb_interp_playback;
    localparam int DEPTH = 2048;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_valid = 1'b0;
    logic               wr_int = 1'b0;
    logic signed [15:0] wr_data = '0;
    logic               scale_load = 1'b0;
    logic [15:0]        scale_value = '0;
    logic [7:0]         interp_len = '0;
    logic               tick = 1'b0;
    logic [11:0]        notify_level = '0;
    logic signed [15:0] out_value;
    logic               running;
    logic [11:0]        fill_level;
    logic               low_notify;
    logic               overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    interp_playback dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_int(wr_int),
        .wr_data(wr_data), .scale_load(scale_load), .scale_value(scale_value),
        .interp_len(interp_len), .tick(tick), .notify_level(notify_level),
        .out_value(out_value), .running(running), .fill_level(fill_level),
        .low_notify(low_notify), .overflow(overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_raw(input int v);
        wr_valid = 1'b1; wr_int = 1'b0; wr_data = 16'(v);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic write_int(input int v);
        wr_valid = 1'b1; wr_int = 1'b1; wr_data = 16'(v);
        @(negedge clk);
        wr_valid = 1'b0; wr_int = 1'b0;
    endtask

    task automatic load_scale(input int s);
        scale_load = 1'b1; scale_value = 16'(s);
        @(negedge clk);
        scale_load = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out", int'(out_value), 0);
        check("R1 running", int'(running), 0);
        check("R1 level", int'(fill_level), DEPTH);
        check("R1 notify", int'(low_notify), 0);
        check("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_ramp();
        int exp_o[16] = '{0,0,0,0,25,50,75,100,125,150,175,200,125,50,-25,0};
        interp_len = 8'd3;
        write_raw(100); write_raw(200); write_raw(-100);
        check("R8 level three", int'(fill_level), 3);
        for (int i = 0; i < 16; i++) begin
            do_tick();
            check($sformatf("R3 ramp tick %0d", i+1), int'(out_value), exp_o[i]);
            if (i == 2)  check("R2 no run before first fetch", int'(running), 0);
            if (i == 3)  check("R2 running on first fetch", int'(running), 1);
            if (i == 7) begin
                repeat (5) @(negedge clk);
                check("R4 out held without tick", int'(out_value), 100);
                check("R4 running held", int'(running), 1);
            end
            if (i == 14) check("R8 empty reads depth", int'(fill_level), DEPTH);
        end
        check("R5 stop clears running", int'(running), 0);
        check("R5 level after stop", int'(fill_level), DEPTH);
    endtask

    task automatic t_truncate();
        int exp_o[9] = '{0,0,0,3,6,10,4,-3,0};
        interp_len = 8'd2;
        write_raw(10); write_raw(-10);
        for (int i = 0; i < 9; i++) begin
            do_tick();
            check($sformatf("R3 truncation tick %0d", i+1), int'(out_value), exp_o[i]);
        end
        check("R5 stopped after truncation run", int'(running), 0);
    endtask

    task automatic t_idle_wrap();
        interp_len = 8'd0;
        do_tick();
        check("R6 idle wrap running", int'(running), 0);
        check("R6 idle wrap out", int'(out_value), 0);
        check("R6 idle wrap level", int'(fill_level), DEPTH);
    endtask

    task automatic t_int_scale();
        int exp_o[8] = '{0,7,-8,300,32767,-32768,0,0};
        interp_len = 8'd0;
        write_int(1000); write_int(-1000);
        load_scale(256);
        write_int(300);
        load_scale(16'hFFFF);
        write_int(32767); write_int(-32768);
        write_raw(0);
        for (int i = 0; i < 8; i++) begin
            do_tick();
            if (i == 0) check("R5 restart first output zero", int'(out_value), 0);
            else check($sformatf("R7 scaled sample %0d", i), int'(out_value), exp_o[i]);
        end
        check("R5 stopped after scale run", int'(running), 0);
    endtask

    task automatic t_notify();
        notify_level = 12'd4;
        interp_len = 8'd0;
        write_raw(1);
        check("R9 notify not yet", int'(low_notify), 0);
        @(negedge clk);
        check("R9 notify on band entry", int'(low_notify), 1);
        @(negedge clk);
        check("R9 notify one cycle", int'(low_notify), 0);
        write_raw(2); write_raw(3);
        @(negedge clk);
        check("R9 no repeat inside band", int'(low_notify), 0);
        write_raw(4);
        @(negedge clk);
        check("R9 leaving band silent", int'(low_notify), 0);
        check("R8 level four", int'(fill_level), 4);
        do_tick();
        @(negedge clk);
        check("R9 notify on re-entry", int'(low_notify), 1);
        repeat (4) do_tick();
        check("R5 drained", int'(running), 0);
        notify_level = 12'd0;
    endtask

    task automatic t_stop_write();
        interp_len = 8'd0;
        write_raw(5);
        do_tick();
        tick = 1'b1; wr_valid = 1'b1; wr_data = 16'sd55;
        @(negedge clk);
        tick = 1'b0; wr_valid = 1'b0;
        check("R11 stopped", int'(running), 0);
        check("R11 level one after stop write", int'(fill_level), 1);
        write_raw(66);
        do_tick();
        check("R11 first output zero", int'(out_value), 0);
        do_tick();
        check("R11 entry 0 plays back", int'(out_value), 55);
        do_tick();
        check("R5 stop after stop-write run", int'(running), 0);
    endtask

    task automatic t_overflow();
        interp_len = 8'd0;
        for (int i = 0; i < DEPTH-1; i++) write_raw(i);
        check("R10 capacity", int'(fill_level), DEPTH-1);
        check("R10 no overflow yet", int'(overflow), 0);
        write_raw(999);
        check("R10 overflow pulse", int'(overflow), 1);
        check("R10 level unchanged", int'(fill_level), DEPTH-1);
        @(negedge clk);
        check("R10 overflow one cycle", int'(overflow), 0);
        do_tick(); do_tick();
        check("R8 level after pops", int'(fill_level), DEPTH-3);
        write_raw(7); write_raw(8);
        check("R8 wrapped level", int'(fill_level), DEPTH-1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ramp();
        t_truncate();
        t_idle_wrap();
        t_int_scale();
        t_notify();
        t_stop_write();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule